// File: doc/BRIEF.md
# Banked Address Translator

This block sits between a 16-bit processor address bus and a larger memory. It splits the address space into 32 regions of 2K words. Each region holds one 16-bit offset. The physical address is the processor address plus the offset for its region, wrapped to 16 bits. Software retargets a region by writing an 8-bit bank selector to one of 32 bank registers. The block stores that write in pre-adjusted form, so the lookup path needs only a table read and one adder.

A write is accepted only if a per-page permission bitmap allows bank changes on the target page. A page here is 256 words. An accepted write that lands on a readable page, while caching is on, also produces a one-cycle cache-invalidate request. The request gives the first and last address of the affected 256-word span. Reads of the bank registers always return all ones.

Top module: `bsw_addr_xlate`

## Requirements
- R1: After reset every offset is zero, so `phys_addr` equals `cpu_addr`, and `inval_valid` is low.
- R2: `phys_addr` = (`cpu_addr` + offset[`cpu_addr[15:11]`]) mod 2^16. This path is combinational from the address and the stored offsets.
- R3: A bank write to index I targets address T, where T[15:12] = I[3:0], T[11] = I[4], and all other bits of T are zero. The entry written is offset[T[15:11]].
- R4: An accepted write of selector S stores ((S << 8) − T) mod 2^16. After it, an address T+k with k < 0x800 translates to (S·256 + k) mod 2^16.
- R5: A write is accepted only if bit T[15:8] of `swap_ok` is 1. Otherwise the table is unchanged and no invalidate is raised. Bits of `swap_ok` for other pages have no effect.
- R6: An accepted write changes `phys_addr` starting in the cycle after the clock edge that samples it. During the write cycle itself the old mapping is still shown.
- R7: `reg_rd_data` is always 16'hFFFF.
- R8: An accepted write with `cache_en` = 1 and bit T[15:8] of `rd_ok` = 1 makes `inval_valid` high for exactly one cycle after the sampling edge, with `inval_lo` = T and `inval_hi` = T + 0xFF.
- R9: An accepted write with `cache_en` = 0, or with a clear readable bit for its page, still updates the table but raises no invalidate.
- R10: A write changes only its own region. Other regions keep their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address to translate |
| phys_addr | output | 16 | Translated memory address |
| wr_en | input | 1 | Bank register write strobe |
| wr_idx | input | 5 | Bank register index |
| wr_sel | input | 8 | Bank selector value |
| swap_ok | input | 256 | Per-page bank-change permission |
| rd_ok | input | 256 | Per-page readable flag |
| cache_en | input | 1 | Caching enabled |
| reg_rd_data | output | 16 | Bank register read data |
| inval_valid | output | 1 | Invalidate request pulse |
| inval_lo | output | 16 | First address to invalidate |
| inval_hi | output | 16 | Last address to invalidate |

## Verification
A lookup and a bank write can fall in the same cycle, and the lookup may hit the very region being rewritten. The bench provokes this by holding `cpu_addr` inside the target region while the write strobe is up. It expects the old mapping before the edge and the new one after it. The invalidate pulse appears in the same cycle as the first lookup under the new mapping. The bench judges that cycle on both outputs together: the translated address, and the pulse with its range.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    localparam int ADDR_W     = 16;
    localparam int IDX_W      = 5;
    localparam int SEL_W      = 8;
    localparam int PAGE_LSB   = 8;
    localparam int REGION_LSB = ADDR_W - IDX_W;
    localparam int NREG       = 1 << IDX_W;
    localparam int NPAGE      = 1 << (ADDR_W - PAGE_LSB);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  fire;
        addr_t lo;
        addr_t hi;
    } inval_t;
endpackage

// File: rtl/bsw_reg_decode.sv
module bsw_reg_decode
    import bsw_pkg::*;
(
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [SEL_W-1:0]     wr_sel_i,
    input  logic [NPAGE-1:0]     swap_ok_i,
    input  logic [NPAGE-1:0]     rd_ok_i,
    input  logic                 cache_en_i,
    output addr_t                tgt_o,
    output logic [IDX_W-1:0]     slot_o,
    output addr_t                entry_o,
    output logic                 accept_o,
    output logic                 want_inval_o
);
    localparam addr_t SUB_MASK = addr_t'(((1 << REGION_LSB) - 1) ^ ((1 << PAGE_LSB) - 1));

    addr_t                      tgt;
    logic [ADDR_W-PAGE_LSB-1:0] page;

    always_comb begin
        tgt                          = '0;
        tgt[ADDR_W-1 -: IDX_W-1]     = wr_idx_i[IDX_W-2:0];
        tgt[REGION_LSB]              = wr_idx_i[IDX_W-1];
        page                         = tgt[ADDR_W-1:PAGE_LSB];
        tgt_o                        = tgt;
        slot_o                       = tgt[ADDR_W-1:REGION_LSB];
        entry_o                      = (addr_t'(wr_sel_i) << PAGE_LSB) - (tgt & ~SUB_MASK);
        accept_o                     = wr_en_i && swap_ok_i[page];
        want_inval_o                 = cache_en_i && rd_ok_i[page];
    end
endmodule

// File: rtl/bsw_offset_table.sv
module bsw_offset_table
    import bsw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [IDX_W-1:0] slot_i,
    input  addr_t            entry_i,
    input  logic [IDX_W-1:0] look_i,
    output addr_t            ofs_o
);
    typedef struct packed {
        logic [NREG-1:0][ADDR_W-1:0] ofs;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.ofs[slot_i] = entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ofs_o = st_q.ofs[look_i];

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> st_q.ofs[$past(slot_i)] == $past(entry_i));

    p_drop_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(st_q));
endmodule

// File: rtl/bsw_inval_gen.sv
module bsw_inval_gen
    import bsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fire_req_i,
    input  addr_t  tgt_i,
    output inval_t inval_o
);
    localparam addr_t SPAN = addr_t'((1 << PAGE_LSB) - 1);

    inval_t inv_d, inv_q;

    always_comb begin
        inv_d      = '0;
        inv_d.fire = fire_req_i;
        if (fire_req_i) begin
            inv_d.lo = tgt_i;
            inv_d.hi = tgt_i | SPAN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= '0;
        else        inv_q <= inv_d;
    end

    assign inval_o = inv_q;

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q.fire |-> $past(fire_req_i));

    p_span_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q.fire |-> (inv_q.hi[ADDR_W-1:PAGE_LSB] == inv_q.lo[ADDR_W-1:PAGE_LSB])
                       && (&inv_q.hi[PAGE_LSB-1:0]));

    p_region_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q.fire |-> inv_q.lo[REGION_LSB-1:0] == '0);
endmodule

// File: rtl/bsw_addr_xlate.sv
module bsw_addr_xlate
    import bsw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    output logic [ADDR_W-1:0]    phys_addr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [NPAGE-1:0]     swap_ok,
    input  logic [NPAGE-1:0]     rd_ok,
    input  logic                 cache_en,
    output logic [ADDR_W-1:0]    reg_rd_data,
    output logic                 inval_valid,
    output logic [ADDR_W-1:0]    inval_lo,
    output logic [ADDR_W-1:0]    inval_hi
);
    addr_t            tgt, entry, ofs;
    logic [IDX_W-1:0] slot;
    logic             accept, want_inval;
    inval_t           inv;

    bsw_reg_decode u_dec (
        .wr_en_i      (wr_en),
        .wr_idx_i     (wr_idx),
        .wr_sel_i     (wr_sel),
        .swap_ok_i    (swap_ok),
        .rd_ok_i      (rd_ok),
        .cache_en_i   (cache_en),
        .tgt_o        (tgt),
        .slot_o       (slot),
        .entry_o      (entry),
        .accept_o     (accept),
        .want_inval_o (want_inval)
    );

    bsw_offset_table u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .slot_i   (slot),
        .entry_i  (entry),
        .look_i   (cpu_addr[ADDR_W-1:REGION_LSB]),
        .ofs_o    (ofs)
    );

    bsw_inval_gen u_inv (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_req_i (accept && want_inval),
        .tgt_i      (tgt),
        .inval_o    (inv)
    );

    assign phys_addr   = cpu_addr + ofs;
    assign reg_rd_data = '1;
    assign inval_valid = inv.fire;
    assign inval_lo    = inv.lo;
    assign inval_hi    = inv.hi;

    p_no_inval_when_cold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cache_en) |=> !inval_valid);
endmodule

// File: tb/bsw_addr_xlate_tb.sv
`timescale 1ns/1ps
module bsw_addr_xlate_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [15:0]  phys_addr;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_idx = '0;
    logic [7:0]   wr_sel = '0;
    logic [255:0] swap_ok = '1;
    logic [255:0] rd_ok = '1;
    logic         cache_en = 1'b1;
    logic [15:0]  reg_rd_data;
    logic         inval_valid;
    logic [15:0]  inval_lo, inval_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bsw_addr_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .swap_ok(swap_ok),
        .rd_ok(rd_ok), .cache_en(cache_en), .reg_rd_data(reg_rd_data),
        .inval_valid(inval_valid), .inval_lo(inval_lo), .inval_hi(inval_hi)
    );

    typedef struct packed {
        logic [4:0]  idx;
        logic [7:0]  sel;
        logic [15:0] probe;
        logic [15:0] exp_phys;
        logic [15:0] exp_lo;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'h01, 8'h23, 16'h1005, 16'h2305, 16'h1000},
        '{5'h11, 8'h40, 16'h1810, 16'h4010, 16'h1800},
        '{5'h00, 8'h80, 16'h00FF, 16'h80FF, 16'h0000},
        '{5'h1F, 8'h01, 16'hFFFF, 16'h08FF, 16'hF800},
        '{5'h10, 8'hFF, 16'h0C00, 16'h0300, 16'h0800},
        '{5'h0A, 8'h00, 16'hA7FF, 16'h07FF, 16'hA000},
        '{5'h0A, 8'h12, 16'h1005, 16'h2305, 16'hA000},
        '{5'h01, 8'h23, 16'h1200, 16'h2500, 16'h1000}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic bank_write(input logic [4:0] idx, input logic [7:0] sel, input logic [15:0] probe);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_sel = sel; cpu_addr = probe;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 identity and quiet after reset, R7 read data
        cpu_addr = 16'h1234; #1 chk("R1 ident", phys_addr, 16'h1234);
        cpu_addr = 16'hFFFF; #1 chk("R1 ident top", phys_addr, 16'hFFFF);
        chk("R1 inval idle", inval_valid, 1'b0);
        chk("R7 read ones", reg_rd_data, 16'hFFFF);

        // R2 R3 R4 R8 R10: vector walk, every write accepted and invalidating
        for (int i = 0; i < NV; i++) begin
            bank_write(VECS[i].idx, VECS[i].sel, VECS[i].probe);
            chk($sformatf("R4 R2 R10 phys v%0d", i), phys_addr, VECS[i].exp_phys);
            chk($sformatf("R8 pulse v%0d", i), inval_valid, 1'b1);
            chk($sformatf("R3 R8 lo v%0d", i), inval_lo, VECS[i].exp_lo);
            chk($sformatf("R8 hi v%0d", i), inval_hi, VECS[i].exp_lo + 16'h00FF);
            @(negedge clk);
            chk($sformatf("R8 one cycle v%0d", i), inval_valid, 1'b0);
        end

        // R5 dropped write: target page 0x30 blocked, neighbour page open
        swap_ok = '1; swap_ok[8'h30] = 1'b0;
        bank_write(5'h03, 8'h55, 16'h3001);
        chk("R5 dropped phys", phys_addr, 16'h3001);
        chk("R5 no inval", inval_valid, 1'b0);
        swap_ok = '1;

        // R9 cache disabled: table updates, no pulse
        cache_en = 1'b0;
        bank_write(5'h04, 8'h66, 16'h4002);
        chk("R9 update cold", phys_addr, 16'h6602);
        chk("R9 no inval cold", inval_valid, 1'b0);
        // R9 page not readable
        cache_en = 1'b1; rd_ok[8'h40] = 1'b0;
        bank_write(5'h04, 8'h77, 16'h4002);
        chk("R9 update unreadable", phys_addr, 16'h7702);
        chk("R9 no inval unreadable", inval_valid, 1'b0);
        rd_ok = '1;

        // R6 same-cycle lookup of the region being rewritten
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'h05; wr_sel = 8'h99; cpu_addr = 16'h5003;
        #1 chk("R6 old map during write", phys_addr, 16'h5003);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 new map after edge", phys_addr, 16'h9903);
        chk("R6 R8 pulse with new map", inval_valid, 1'b1);
        chk("R7 read ones later", reg_rd_data, 16'hFFFF);

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule